// File: doc/BRIEF.md
# Floating-Point Issue Structural Hazard Checker

This block decides, one cycle at a time, whether a floating-point operation may enter a unit whose internal stages are shared between operation kinds. There are eight stage resources: unpack, operand shift, mantissa add, rounding, multiplier first stage, multiplier second stage, exception test and divide iteration. Each operation kind uses a fixed set of these resources in each cycle after it enters. The multiply and divide sequences finish on the adder and rounding resources, so an add can collide with a multiply or divide that is already in flight.

The checker holds a reservation table with one resource mask per future cycle. Slot 0 is the current cycle. On every clock the table moves one slot toward slot 0. An issue request is granted in the same cycle only when the operation's usage pattern, laid over the table from slot 0 onward, hits no reserved resource. A granted operation's pattern is merged into the table at that clock edge. A refused request is reported as a stall, and the issuer holds it and retries in the next cycle. At most one operation is accepted per cycle. The arithmetic itself is not part of this block.

Top module: `fp_issue_hazard_check`

## Requirements
- R1: A synchronous active-low reset empties the reservation table. In the cycle after reset, `busy_now` is 0 and any request is granted.
- R2: `issue_grant` is high only while `issue_req` is high. `issue_stall` is high exactly when a request is present and not granted. With no request, both outputs are low.
- R3: Resource bit encoding in `busy_now` is: unpack bit 0, shift bit 1, add bit 2, round bit 3, multiplier-one bit 4, multiplier-two bit 5, exception-test bit 6, divide bit 7. Opcode encoding is: add/subtract 0, multiply 1, divide 2, negate 3, absolute 4, compare 5. An add uses unpack in the cycle it issues. In the three cycles after a granted add, `busy_now` reads 0x06, 0x0C and 0x0A, then 0x00.
- R4: An add issued one or two cycles after another add is stalled. An add issued three cycles after it is granted.
- R5: A multiply uses unpack, then exception-test with multiplier-one, then multiplier-one for three cycles, then multiplier-two. After a granted multiply, `busy_now` reads 0x50, 0x10, 0x10, 0x10, 0x20. A second multiply one cycle later is stalled.
- R6: The last two cycles of a multiply use multiplier-two with add (0x24), then round (0x08). An add that would need the adder in those cycles is stalled.
- R7: A divide (default of 12 iterations) uses unpack, add, round, the divide stage for 12 cycles, divide with add, divide with round, add, round. A second divide that overlaps the iterations is stalled. An add that collides with the divide tail is stalled.
- R8: Negate and absolute use unpack then shift. Compare uses unpack, add, round. These can issue on consecutive cycles when their patterns interleave.
- R9: Opcodes 6 and 7 are granted whenever requested and reserve nothing, so `busy_now` stays 0 afterward.
- R10: A stalled request leaves the reservation table unchanged. A grant is never given when the unpack resource is already reserved for the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_req | input | 1 | Request to issue an operation this cycle |
| issue_op | input | 3 | Operation kind of the request |
| issue_grant | output | 1 | Request accepted this cycle |
| issue_stall | output | 1 | Request refused this cycle; retry next cycle |
| busy_now | output | 8 | Resources held in the current cycle by earlier grants |

## Verification
The properties assume that `issue_op` is stable and defined whenever `issue_req` is high. They also assume that the issuer keeps a refused request unchanged for the retry. The property on the first-cycle unpack resource applies only to the six defined opcodes. The stimulus changes inputs only on the falling edge and repeats each stalled opcode in the following cycle. Reserved opcodes are used only in dedicated directed steps.

// File: rtl/fp_hz_pkg.sv
package fp_hz_pkg;
    // Number of shared stage resources tracked per cycle
    localparam int NRES = 8;

    // Bit positions of each resource inside a usage mask
    localparam int RES_U = 0;  // unpack
    localparam int RES_S = 1;  // operand shift
    localparam int RES_A = 2;  // mantissa add
    localparam int RES_R = 3;  // rounding
    localparam int RES_M = 4;  // multiplier first stage
    localparam int RES_N = 5;  // multiplier second stage
    localparam int RES_E = 6;  // exception test
    localparam int RES_D = 7;  // divide iteration

    typedef logic [NRES-1:0] res_mask_t;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_DIV  = 3'd2,
        OP_NEG  = 3'd3,
        OP_ABS  = 3'd4,
        OP_CMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } fp_op_e;
endpackage

// File: rtl/fp_pattern_gen.sv
// Builds the per-cycle resource usage pattern of one operation kind.
// Slot k of the output is the resource mask needed k cycles after issue.
// Assumes DEPTH >= DIV_ITER + 7 and DIV_ITER >= 1 (multiply needs 8 slots).
module fp_pattern_gen
    import fp_hz_pkg::*;
#(
    parameter int DIV_ITER = 12,
    parameter int DEPTH    = DIV_ITER + 7
) (
    input  logic [2:0]                 op,
    output logic [DEPTH-1:0][NRES-1:0] pat
);
    // Decode the opcode into its reservation pattern
    always_comb begin
        pat = '0;
        case (fp_op_e'(op))
            OP_ADD: begin
                pat[0][RES_U] = 1'b1;
                pat[1][RES_S] = 1'b1;
                pat[1][RES_A] = 1'b1;
                pat[2][RES_A] = 1'b1;
                pat[2][RES_R] = 1'b1;
                pat[3][RES_R] = 1'b1;
                pat[3][RES_S] = 1'b1;
            end
            OP_MUL: begin
                pat[0][RES_U] = 1'b1;
                pat[1][RES_E] = 1'b1;
                pat[1][RES_M] = 1'b1;
                for (int k = 2; k < 5; k++) pat[k][RES_M] = 1'b1;
                pat[5][RES_N] = 1'b1;
                pat[6][RES_N] = 1'b1;
                pat[6][RES_A] = 1'b1;
                pat[7][RES_R] = 1'b1;
            end
            OP_DIV: begin
                pat[0][RES_U] = 1'b1;
                pat[1][RES_A] = 1'b1;
                pat[2][RES_R] = 1'b1;
                for (int k = 0; k < DIV_ITER + 2; k++) pat[3+k][RES_D] = 1'b1;
                pat[3+DIV_ITER][RES_A] = 1'b1;
                pat[4+DIV_ITER][RES_R] = 1'b1;
                pat[5+DIV_ITER][RES_A] = 1'b1;
                pat[6+DIV_ITER][RES_R] = 1'b1;
            end
            OP_NEG, OP_ABS: begin
                pat[0][RES_U] = 1'b1;
                pat[1][RES_S] = 1'b1;
            end
            OP_CMP: begin
                pat[0][RES_U] = 1'b1;
                pat[1][RES_A] = 1'b1;
                pat[2][RES_R] = 1'b1;
            end
            default: pat = '0;
        endcase
    end
endmodule

// File: rtl/fp_conflict_detect.sv
// Compares a candidate pattern against the reservation table, slot by slot.
// Assumes both arrays are aligned so that slot 0 is the current cycle.
module fp_conflict_detect
    import fp_hz_pkg::*;
#(
    parameter int DEPTH = 19
) (
    input  logic [DEPTH-1:0][NRES-1:0] resv,
    input  logic [DEPTH-1:0][NRES-1:0] pat,
    output logic                       conflict
);
    logic [DEPTH-1:0] slot_hit;

    // One overlap flag per future cycle
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slot_hit[i] = |(resv[i] & pat[i]);
    end

    assign conflict = |slot_hit;
endmodule

// File: rtl/fp_resv_shift.sv
// Reservation table: advances one slot per clock and merges a granted pattern.
// Assumes merge_en is asserted only for a pattern that passed the conflict check.
module fp_resv_shift
    import fp_hz_pkg::*;
#(
    parameter int DEPTH = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       merge_en,
    input  logic [DEPTH-1:0][NRES-1:0] pat,
    output logic [DEPTH-1:0][NRES-1:0] resv
);
    logic [DEPTH-1:0][NRES-1:0] resv_nxt;

    // Next content of each slot: older slot moved down plus new reservations
    for (genvar i = 0; i < DEPTH; i++) begin : g_next
        if (i < DEPTH - 1) begin : g_mid
            assign resv_nxt[i] = resv[i+1] | (merge_en ? pat[i+1] : '0);
        end else begin : g_top
            assign resv_nxt[i] = '0;
        end
    end

    // Register the table with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) resv <= '0;
        else        resv <= resv_nxt;
    end
endmodule

// File: rtl/fp_issue_hazard_check.sv
// Issue-time structural hazard checker for a shared-stage FP unit.
// Grants a request in the same cycle when its pattern fits the table.
// Assumes the issuer holds a stalled request and retries next cycle.
module fp_issue_hazard_check
    import fp_hz_pkg::*;
#(
    parameter int DIV_ITER = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_req,
    input  logic [2:0] issue_op,
    output logic       issue_grant,
    output logic       issue_stall,
    output logic [7:0] busy_now
);
    localparam int DEPTH = DIV_ITER + 7;

    logic [DEPTH-1:0][NRES-1:0] pat;
    logic [DEPTH-1:0][NRES-1:0] resv;
    logic                       conflict;

    fp_pattern_gen #(.DIV_ITER(DIV_ITER), .DEPTH(DEPTH)) i_pat (
        .op  (issue_op),
        .pat (pat)
    );

    fp_conflict_detect #(.DEPTH(DEPTH)) i_cmp (
        .resv     (resv),
        .pat      (pat),
        .conflict (conflict)
    );

    fp_resv_shift #(.DEPTH(DEPTH)) i_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .merge_en (issue_grant),
        .pat      (pat),
        .resv     (resv)
    );

    // Accept when requested and free of overlap
    assign issue_grant = issue_req && !conflict;
    assign issue_stall = issue_req && conflict;
    assign busy_now    = resv[0];
endmodule

// File: rtl/fp_issue_hazard_sva.sv
// Property checker for fp_issue_hazard_check, attached through bind.
// Assumes issue_op is defined whenever issue_req is high.
module fp_issue_hazard_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       issue_req,
    input logic [2:0] issue_op,
    input logic       issue_grant,
    input logic       issue_stall,
    input logic [7:0] busy_now
);
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> issue_req);

    assert_req_resolved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_req |-> (issue_grant != issue_stall));

    assert_unpack_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && issue_op < 3'd6) |-> !busy_now[0]);

    assert_add_second_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && issue_op == 3'd0) |=> (busy_now[1] && busy_now[2]));

    assert_mul_second_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && issue_op == 3'd1) |=> (busy_now[6] && busy_now[4]));
endmodule

bind fp_issue_hazard_check fp_issue_hazard_sva i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_req   (issue_req),
    .issue_op    (issue_op),
    .issue_grant (issue_grant),
    .issue_stall (issue_stall),
    .busy_now    (busy_now)
);

// File: tb/test_fp_issue_hazard_check.sv
module test_fp_issue_hazard_check;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_req = 1'b0;
    logic [2:0] issue_op = 3'd0;
    logic       issue_grant;
    logic       issue_stall;
    logic [7:0] busy_now;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fp_issue_hazard_check i_fp_issue_hazard_check (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_op(issue_op),
        .issue_grant(issue_grant), .issue_stall(issue_stall), .busy_now(busy_now)
    );

    always #10 clk = ~clk;

    // {req, op, expected grant}; each entry is one cycle
    localparam int NV = 40;
    localparam logic [4:0] VEC [NV] = '{
        {1'b1,3'd0,1'b1}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b1},
        {1'b1,3'd3,1'b1}, {1'b1,3'd5,1'b1}, {1'b1,3'd4,1'b1}, {1'b0,3'd0,1'b0},
        {1'b1,3'd1,1'b1}, {1'b1,3'd1,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0},
        {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b1}, {1'b1,3'd4,1'b1},
        {1'b1,3'd5,1'b1}, {1'b1,3'd5,1'b1}, {1'b1,3'd5,1'b1}, {1'b0,3'd0,1'b0},
        {1'b0,3'd0,1'b0}, {1'b1,3'd2,1'b1}, {1'b1,3'd5,1'b1}, {1'b1,3'd2,1'b0},
        {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0},
        {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0},
        {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b0,3'd0,1'b0}, {1'b1,3'd0,1'b0},
        {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b1}, {1'b1,3'd0,1'b0}
    };

    function automatic string tag_of(input logic req, input logic [2:0] op, input int idx);
        if (!req)                         return "R2";
        if (idx >= 12 && idx <= 14)       return "R6";
        case (op)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle on the falling edge, then settle before sampling
    task automatic step(input logic req, input logic [2:0] op);
        @(negedge clk);
        issue_req = req;
        issue_op  = op;
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        issue_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: empty table after reset, idle outputs
        step(1'b0, 3'd0);
        check("R1 busy", busy_now, 8'h00);
        check("R2 idle grant", {7'd0, issue_grant}, 8'h00);
        check("R2 idle stall", {7'd0, issue_stall}, 8'h00);

        // Vector walk over mixed traffic
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][4], VEC[v][3:1]);
            check($sformatf("%s vec %0d grant", tag_of(VEC[v][4], VEC[v][3:1], v), v),
                  {7'd0, issue_grant}, {7'd0, VEC[v][0]});
            check($sformatf("R2 vec %0d stall", v),
                  {7'd0, issue_stall}, {7'd0, VEC[v][4] & ~VEC[v][0]});
        end

        // R1: reset in mid-flight clears everything
        do_reset();
        step(1'b1, 3'd2);
        check("R1 div after reset", {7'd0, issue_grant}, 8'h01);
        do_reset();
        step(1'b0, 3'd0);
        check("R1 busy after mid-flight reset", busy_now, 8'h00);

        // R3 and R10: add footprint, with a stalled add in between
        step(1'b1, 3'd0);
        check("R3 add grant", {7'd0, issue_grant}, 8'h01);
        step(1'b1, 3'd0);
        check("R10 add stalled", {7'd0, issue_stall}, 8'h01);
        check("R3 busy +1", busy_now, 8'h06);
        step(1'b0, 3'd0);
        check("R10 busy +2", busy_now, 8'h0C);
        step(1'b0, 3'd0);
        check("R10 busy +3", busy_now, 8'h0A);
        step(1'b0, 3'd0);
        check("R3 busy +4", busy_now, 8'h00);

        // R5 and R6: multiply footprint
        step(1'b1, 3'd1);
        check("R5 mul grant", {7'd0, issue_grant}, 8'h01);
        step(1'b0, 3'd0); check("R5 busy +1", busy_now, 8'h50);
        step(1'b0, 3'd0); check("R5 busy +2", busy_now, 8'h10);
        step(1'b0, 3'd0); check("R5 busy +3", busy_now, 8'h10);
        step(1'b0, 3'd0); check("R5 busy +4", busy_now, 8'h10);
        step(1'b0, 3'd0); check("R5 busy +5", busy_now, 8'h20);
        step(1'b0, 3'd0); check("R6 busy +6", busy_now, 8'h24);
        step(1'b0, 3'd0); check("R6 busy +7", busy_now, 8'h08);
        step(1'b0, 3'd0); check("R6 busy +8", busy_now, 8'h00);

        // R9: reserved opcodes pass and reserve nothing
        step(1'b1, 3'd6);
        check("R9 op6 grant", {7'd0, issue_grant}, 8'h01);
        step(1'b1, 3'd7);
        check("R9 op7 grant", {7'd0, issue_grant}, 8'h01);
        check("R9 busy after op6", busy_now, 8'h00);
        step(1'b0, 3'd0);
        check("R9 busy after op7", busy_now, 8'h00);

        // R8: negate footprint
        step(1'b1, 3'd3);
        check("R8 neg grant", {7'd0, issue_grant}, 8'h01);
        step(1'b0, 3'd0);
        check("R8 neg busy +1", busy_now, 8'h02);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule